// File: doc/BRIEF.md
# Session Key Lifetime Controller

This block decides when the symmetric session key in use must be replaced, and it keeps track of which key slots are live. It counts seconds from an external one-pulse-per-second tick and sums payload bytes from per-packet counts. When either count crosses its limit, it raises a rotation request. The request drops only when the peer reports that a replacement key is installed in another slot. At that handover the old slot becomes "retiring": it can still decrypt traffic for a grace window measured in ticks. After the window the block wipes the old slot. A wipe takes the same fixed number of cycles whatever the key holds, and a done pulse marks its end.

Two alarms override the normal lifecycle. A tamper alarm wipes all slots at once and leaves no valid key. A report that a stored key is corrupt has an effect only when it names the active slot or the retiring slot. For the active slot, the block withdraws that key and raises a re-derivation request that carries the slot index. For the retiring slot, the wipe starts early. Key derivation, key exchange and the cipher sit outside the block. This block only sequences the states of the slots.

Top module: `key_lifetime_ctrl`

## Requirements
- R1: With defaults, `rotateReq` goes high in the cycle after the 600th accepted `secTick` since the current key was installed, and is low after 599.
- R2: Packet byte counts add into a 64-bit saturating total. `rotateReq` goes high in the cycle after the packet that brings the total to at least 2^30.
- R3: Both counters restart only when a replacement key is accepted. `rotateReq` stays high until then, however many more ticks arrive.
- R4: `newKeyReady` has no effect when there is no pending request and no key is missing, or when `newKeySlot` equals `activeSlot`.
- R5: An accepted rotation takes effect on the next cycle. `activeSlot` becomes `newKeySlot`, `retireSlot` takes the previous active slot, and `retireValid` is high. The slot stays unwiped through 29 ticks of the 30-tick grace window.
- R6: The 30th grace tick starts a wipe. `zeroMask` is a one-hot mask with bit i meaning slot i. `zeroBusy` is high for exactly 8 cycles, `zeroDone` pulses as it falls, and `retireValid` drops on the cycle after the pulse.
- R7: A limit that is reached while a retiring slot exists does not raise `rotateReq` until that slot has been wiped. After the wipe, the held request appears.
- R8: `tamperAlarm` causes, on the next cycle: `zeroMask` all ones, `activeValid` and `retireValid` low, `needKey` high. A key offered while the wipe is still busy is refused. After the wipe, a key is installed without a grace window.
- R9: A corruption report on the active slot pulses `rederiveReq` for one cycle with `rederiveSlot` set to that slot, and drops `activeValid`. Any following key is then accepted, including one in the same slot.
- R10: A corruption report on the retiring slot starts its wipe on the next cycle. A report on any other slot has no effect.
- R11: After reset, slot 0 is active and valid, no slot is retiring, and no request or wipe is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle pulse per elapsed second |
| pktValid | input | 1 | A packet count is present this cycle |
| pktBytes | input | 16 | Bytes carried by the packet |
| newKeyReady | input | 1 | Peer reports a replacement key installed |
| newKeySlot | input | 4 | Slot that holds the replacement key |
| tamperAlarm | input | 1 | Physical intrusion detected |
| corruptAlarm | input | 1 | A stored key failed its integrity check |
| corruptSlot | input | 4 | Slot that failed the check |
| rotateReq | output | 1 | Replacement key wanted (age or volume limit) |
| needKey | output | 1 | No usable active key |
| activeSlot | output | 4 | Slot used for new traffic |
| activeValid | output | 1 | Active slot holds a usable key |
| retireSlot | output | 4 | Previous slot still allowed to decrypt |
| retireValid | output | 1 | A retiring slot exists |
| zeroBusy | output | 1 | A wipe is in progress |
| zeroMask | output | 16 | Slots being wiped, bit i for slot i |
| zeroDone | output | 1 | One-cycle pulse at the end of a wipe |
| rederiveReq | output | 1 | One-cycle request to derive a corrupted key again |
| rederiveSlot | output | 4 | Slot to derive again |

## Verification
The age trigger is driven by a continuous stream of ticks and checked at the 599/600 boundary, which exposes an off-by-one in either direction. The volume trigger is driven by a seeded random stream of packet sizes. The cycle on which the request first appears is compared with a running sum kept in the bench. A second run with maximum-size packets during a grace window shows whether the request is held or leaks. The tamper, corrupt-active, corrupt-retiring and corrupt-unrelated patterns each land on a different state. Each one is told apart by the wipe mask, the validity flags, and whether a following key offer is taken or refused.

// File: rtl/klc_pkg.sv
package klc_pkg;

  // Strobes from the sequencing control to the counting datapath.
  typedef struct packed {
    logic clrCounters;
    logic startGrace;
    logic stopGrace;
    logic zeroStart;
    logic zeroAll;
  } ctlStrobe_t;

  // Status returned by the datapath.
  typedef struct packed {
    logic limitHit;
    logic graceExpire;
    logic zeroBusy;
    logic zeroDone;
  } dpStatus_t;

endpackage

// File: rtl/klc_zeroizer.sv
module klc_zeroizer #(
  parameter int NUM_SLOTS   = 16,
  parameter int ZERO_CYCLES = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int ZERO_W = $clog2(ZERO_CYCLES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 wipeAll,
  input  logic [SLOT_W-1:0]    slot,
  output logic                 busy,
  output logic [NUM_SLOTS-1:0] mask,
  output logic                 done
);

  logic [NUM_SLOTS-1:0] maskNext;
  logic [ZERO_W-1:0]    cnt;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_mask
    assign maskNext[i] = wipeAll || (slot == SLOT_W'(i));
  end

  // The duration is fixed and does not depend on what is stored (R6).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      mask <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        mask <= maskNext;
        cnt  <= ZERO_W'(ZERO_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          mask <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R6
  wipe_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busy && (mask != '0));

  // R6
  wipe_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));

endmodule

// File: rtl/klc_datapath.sv
module klc_datapath import klc_pkg::*; #(
  parameter int NUM_SLOTS       = 16,
  parameter int PKT_W           = 16,
  parameter int AGE_LIMIT       = 600,
  parameter int GRACE_TICKS     = 30,
  parameter int BYTE_LIMIT_LOG2 = 30,
  parameter int ZERO_CYCLES     = 8,
  localparam int SLOT_W  = $clog2(NUM_SLOTS),
  localparam int BYTE_W  = 64,
  localparam int AGE_W   = $clog2(AGE_LIMIT + 1),
  localparam int GRACE_W = $clog2(GRACE_TICKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 secTick,
  input  logic                 pktValid,
  input  logic [PKT_W-1:0]     pktBytes,
  input  ctlStrobe_t           strobe,
  input  logic [SLOT_W-1:0]    zeroSlot,
  output dpStatus_t            stat,
  output logic [NUM_SLOTS-1:0] zeroMask
);

  localparam logic [BYTE_W-1:0] BYTE_LIMIT = BYTE_W'(1) << BYTE_LIMIT_LOG2;

  logic [AGE_W-1:0]   ageCnt;
  logic [BYTE_W-1:0]  byteCnt;
  logic [BYTE_W:0]    byteSum;
  logic [GRACE_W-1:0] graceCnt;
  logic               graceRun;
  logic               zBusy;
  logic               zDone;

  assign byteSum = {1'b0, byteCnt} + {{(BYTE_W + 1 - PKT_W){1'b0}}, pktBytes};

  // Key age in ticks, held at the limit (R1).
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrCounters) begin
      ageCnt <= '0;
    end else if (secTick && (ageCnt != AGE_W'(AGE_LIMIT))) begin
      ageCnt <= ageCnt + 1'b1;
    end
  end

  // Traffic volume, saturating at all ones (R2).
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrCounters) begin
      byteCnt <= '0;
    end else if (pktValid) begin
      byteCnt <= byteSum[BYTE_W] ? '1 : byteSum[BYTE_W-1:0];
    end
  end

  // Grace window counter for the retiring slot (R5).
  always_ff @(posedge clk) begin
    if (!rstN || strobe.stopGrace) begin
      graceRun <= 1'b0;
      graceCnt <= '0;
    end else if (strobe.startGrace) begin
      graceRun <= 1'b1;
      graceCnt <= '0;
    end else if (stat.graceExpire) begin
      graceRun <= 1'b0;
      graceCnt <= '0;
    end else if (graceRun && secTick) begin
      graceCnt <= graceCnt + 1'b1;
    end
  end

  klc_zeroizer #(
    .NUM_SLOTS   (NUM_SLOTS),
    .ZERO_CYCLES (ZERO_CYCLES)
  ) u_zeroizer (
    .clk     (clk),
    .rstN    (rstN),
    .start   (strobe.zeroStart),
    .wipeAll (strobe.zeroAll),
    .slot    (zeroSlot),
    .busy    (zBusy),
    .mask    (zeroMask),
    .done    (zDone)
  );

  always_comb begin
    stat.limitHit    = (ageCnt == AGE_W'(AGE_LIMIT)) || (byteCnt >= BYTE_LIMIT);
    stat.graceExpire = graceRun && secTick && (graceCnt == GRACE_W'(GRACE_TICKS - 1));
    stat.zeroBusy    = zBusy;
    stat.zeroDone    = zDone;
  end

  // R3
  counters_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCounters |=> !stat.limitHit);

  // R2
  byte_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrCounters |=> byteCnt >= $past(byteCnt));

endmodule

// File: rtl/klc_control.sv
module klc_control import klc_pkg::*; #(
  parameter int NUM_SLOTS = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 newKeyReady,
  input  logic [SLOT_W-1:0]    newKeySlot,
  input  logic                 tamperAlarm,
  input  logic                 corruptAlarm,
  input  logic [SLOT_W-1:0]    corruptSlot,
  input  dpStatus_t            stat,
  input  logic [NUM_SLOTS-1:0] zeroMask,
  output ctlStrobe_t           strobe,
  output logic [SLOT_W-1:0]    zeroSlot,
  output logic                 rotateReq,
  output logic [SLOT_W-1:0]    activeSlot,
  output logic                 activeValid,
  output logic [SLOT_W-1:0]    retireSlot,
  output logic                 retireValid,
  output logic                 rederiveReq,
  output logic [SLOT_W-1:0]    rederiveSlot
);

  logic slotClash;
  logic rotateAccept;
  logic recoverAccept;
  logic acceptGo;
  logic corruptActive;
  logic corruptRetire;

  // A limit hit during a transition stays pending (R7).
  assign rotateReq     = activeValid && !retireValid && stat.limitHit;
  assign slotClash     = retireValid && (newKeySlot == retireSlot);
  // Offers with no request or into the active slot are dropped (R4).
  assign rotateAccept  = newKeyReady && rotateReq && (newKeySlot != activeSlot);
  assign recoverAccept = newKeyReady && !activeValid && !stat.zeroBusy && !slotClash;
  assign acceptGo      = !tamperAlarm && !corruptAlarm && (rotateAccept || recoverAccept);
  assign corruptActive = corruptAlarm && activeValid && (corruptSlot == activeSlot);
  assign corruptRetire = corruptAlarm && retireValid && (corruptSlot == retireSlot)
                         && !stat.zeroBusy;

  always_comb begin
    strobe   = '0;
    zeroSlot = retireSlot;
    if (tamperAlarm) begin
      strobe.zeroStart = 1'b1;
      strobe.zeroAll   = 1'b1;
      strobe.stopGrace = 1'b1;
    end else begin
      if (corruptRetire) begin
        strobe.zeroStart = 1'b1;
        strobe.stopGrace = 1'b1;
      end else if (stat.graceExpire) begin
        strobe.zeroStart = 1'b1;
      end
      strobe.clrCounters = acceptGo;
      strobe.startGrace  = acceptGo && rotateAccept;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSlot   <= '0;
      activeValid  <= 1'b1;
      retireSlot   <= '0;
      retireValid  <= 1'b0;
      rederiveReq  <= 1'b0;
      rederiveSlot <= '0;
    end else begin
      rederiveReq <= 1'b0;
      if (stat.zeroDone) begin
        retireValid <= 1'b0;
      end
      if (tamperAlarm) begin
        activeValid <= 1'b0;
        retireValid <= 1'b0;
      end else if (corruptActive) begin
        activeValid  <= 1'b0;
        rederiveReq  <= 1'b1;
        rederiveSlot <= corruptSlot;
      end else if (acceptGo) begin
        activeSlot  <= newKeySlot;
        activeValid <= 1'b1;
        if (rotateAccept) begin
          retireSlot  <= activeSlot;
          retireValid <= 1'b1;
        end
      end
    end
  end

  // R8
  tamper_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    tamperAlarm |=> !activeValid && !retireValid && (zeroMask == '1));

  // R5
  handover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rotateAccept && !tamperAlarm && !corruptAlarm)
      |=> retireValid && (retireSlot == $past(activeSlot)));

  // R6
  release_after_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(retireValid) && !$past(tamperAlarm)) |-> $past(stat.zeroDone));

  // R9
  rederive_chk: assert property (@(posedge clk) disable iff (!rstN)
    rederiveReq |-> !activeValid);

endmodule

// File: rtl/key_lifetime_ctrl.sv
module key_lifetime_ctrl import klc_pkg::*; #(
  parameter int NUM_SLOTS       = 16,
  parameter int PKT_W           = 16,
  parameter int AGE_LIMIT       = 600,
  parameter int GRACE_TICKS     = 30,
  parameter int BYTE_LIMIT_LOG2 = 30,
  parameter int ZERO_CYCLES     = 8,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 secTick,
  input  logic                 pktValid,
  input  logic [PKT_W-1:0]     pktBytes,
  input  logic                 newKeyReady,
  input  logic [SLOT_W-1:0]    newKeySlot,
  input  logic                 tamperAlarm,
  input  logic                 corruptAlarm,
  input  logic [SLOT_W-1:0]    corruptSlot,
  output logic                 rotateReq,
  output logic                 needKey,
  output logic [SLOT_W-1:0]    activeSlot,
  output logic                 activeValid,
  output logic [SLOT_W-1:0]    retireSlot,
  output logic                 retireValid,
  output logic                 zeroBusy,
  output logic [NUM_SLOTS-1:0] zeroMask,
  output logic                 zeroDone,
  output logic                 rederiveReq,
  output logic [SLOT_W-1:0]    rederiveSlot
);

  ctlStrobe_t        strobe;
  dpStatus_t         stat;
  logic [SLOT_W-1:0] zeroSlot;

  klc_control #(.NUM_SLOTS(NUM_SLOTS)) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .newKeyReady  (newKeyReady),
    .newKeySlot   (newKeySlot),
    .tamperAlarm  (tamperAlarm),
    .corruptAlarm (corruptAlarm),
    .corruptSlot  (corruptSlot),
    .stat         (stat),
    .zeroMask     (zeroMask),
    .strobe       (strobe),
    .zeroSlot     (zeroSlot),
    .rotateReq    (rotateReq),
    .activeSlot   (activeSlot),
    .activeValid  (activeValid),
    .retireSlot   (retireSlot),
    .retireValid  (retireValid),
    .rederiveReq  (rederiveReq),
    .rederiveSlot (rederiveSlot)
  );

  klc_datapath #(
    .NUM_SLOTS       (NUM_SLOTS),
    .PKT_W           (PKT_W),
    .AGE_LIMIT       (AGE_LIMIT),
    .GRACE_TICKS     (GRACE_TICKS),
    .BYTE_LIMIT_LOG2 (BYTE_LIMIT_LOG2),
    .ZERO_CYCLES     (ZERO_CYCLES)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .secTick  (secTick),
    .pktValid (pktValid),
    .pktBytes (pktBytes),
    .strobe   (strobe),
    .zeroSlot (zeroSlot),
    .stat     (stat),
    .zeroMask (zeroMask)
  );

  assign needKey  = !activeValid;
  assign zeroBusy = stat.zeroBusy;
  assign zeroDone = stat.zeroDone;

endmodule

// File: tb/tb_key_lifetime_ctrl.sv
`timescale 1ns/1ps
module tb_key_lifetime_ctrl;

  localparam int  AGE_LIM = 600;
  localparam int  GRACE   = 30;
  localparam int  ZCYC    = 8;
  localparam longint unsigned BLIM = 64'd1 << 30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        secTick = 1'b0;
  logic        pktValid = 1'b0;
  logic [15:0] pktBytes = '0;
  logic        newKeyReady = 1'b0;
  logic [3:0]  newKeySlot = '0;
  logic        tamperAlarm = 1'b0;
  logic        corruptAlarm = 1'b0;
  logic [3:0]  corruptSlot = '0;
  logic        rotateReq, needKey, activeValid, retireValid, zeroBusy, zeroDone, rederiveReq;
  logic [3:0]  activeSlot, retireSlot, rederiveSlot;
  logic [15:0] zeroMask;

  int  nTests = 0;
  int  nFail  = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  key_lifetime_ctrl dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .pktValid(pktValid), .pktBytes(pktBytes),
    .newKeyReady(newKeyReady), .newKeySlot(newKeySlot), .tamperAlarm(tamperAlarm),
    .corruptAlarm(corruptAlarm), .corruptSlot(corruptSlot), .rotateReq(rotateReq),
    .needKey(needKey), .activeSlot(activeSlot), .activeValid(activeValid),
    .retireSlot(retireSlot), .retireValid(retireValid), .zeroBusy(zeroBusy),
    .zeroMask(zeroMask), .zeroDone(zeroDone), .rederiveReq(rederiveReq),
    .rederiveSlot(rederiveSlot)
  );

  function automatic bit expReq(longint unsigned bytes, int age);
    return (bytes >= BLIM) || (age >= AGE_LIM);
  endfunction

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    secTick = 1'b1;
    for (int i = 0; i < n; i++) step();
    secTick = 1'b0;
  endtask

  task automatic offer(input logic [3:0] s);
    newKeySlot  = s;
    newKeyReady = 1'b1;
    step();
    newKeyReady = 1'b0;
  endtask

  task automatic waitWipe(output int busyCycles);
    busyCycles = 0;
    while (zeroBusy && busyCycles < 100) begin
      busyCycles++;
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int  bc;
    longint unsigned sum;
    int  modelFirst, seenFirst;
    void'($urandom(32'd20240611));
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R11 reset state
    check("R11", "activeSlot", activeSlot, 0);
    check("R11", "activeValid", activeValid, 1);
    check("R11", "retireValid", retireValid, 0);
    check("R11", "rotateReq", rotateReq, 0);
    check("R11", "zeroBusy", zeroBusy, 0);

    // R1 age boundary
    ticks(AGE_LIM - 1);
    check("R1", "req after 599 ticks", rotateReq, expReq(0, AGE_LIM - 1));
    ticks(1);
    check("R1", "req after 600 ticks", rotateReq, expReq(0, AGE_LIM));
    // R3 request persists
    ticks(5);
    check("R3", "req held until new key", rotateReq, 1);

    // R4 offer into the active slot is dropped
    offer(4'd0);
    check("R4", "same-slot offer activeSlot", activeSlot, 0);
    check("R4", "same-slot offer req", rotateReq, 1);

    // R5 handover
    offer(4'd5);
    check("R5", "activeSlot", activeSlot, 5);
    check("R5", "retireSlot", retireSlot, 0);
    check("R5", "retireValid", retireValid, 1);
    check("R3", "req cleared by install", rotateReq, 0);
    ticks(GRACE - 1);
    check("R5", "retire kept through grace", retireValid, 1);
    check("R5", "no wipe in grace", zeroBusy, 0);

    // R6 wipe at grace end
    ticks(1);
    check("R6", "wipe started", zeroBusy, 1);
    check("R6", "wipe mask", zeroMask, 16'h0001);
    waitWipe(bc);
    check("R6", "wipe cycles", bc, ZCYC);
    check("R6", "done pulse", zeroDone, 1);
    step();
    check("R6", "retire released", retireValid, 0);
    check("R6", "done is a pulse", zeroDone, 0);

    // R4 offer with no request is dropped
    offer(4'd7);
    check("R4", "unrequested offer", activeSlot, 5);

    // R2 random volume stream
    sum = 0; modelFirst = -1; seenFirst = -1;
    for (int i = 0; i < 40000 && seenFirst < 0; i++) begin
      pktBytes = 16'(($urandom % 65535) + 1);
      pktValid = 1'b1;
      step();
      sum += pktBytes;
      if (modelFirst < 0 && expReq(sum, GRACE)) modelFirst = i;
      if (rotateReq) seenFirst = i;
    end
    pktValid = 1'b0;
    check("R2", "first packet raising req", seenFirst, modelFirst);

    // R7 trigger inside a transition is held
    offer(4'd9);
    pktBytes = 16'hFFFF;
    pktValid = 1'b1;
    for (int i = 0; i < 16385; i++) step();
    pktValid = 1'b0;
    check("R7", "req held during grace", rotateReq, 0);
    ticks(GRACE);
    waitWipe(bc);
    check("R7", "req still held after wipe end", rotateReq, 0);
    step();
    check("R7", "req released after wipe", rotateReq, 1);

    // R10 unrelated slot ignored
    corruptSlot = 4'd2; corruptAlarm = 1'b1; step(); corruptAlarm = 1'b0;
    check("R10", "unrelated corrupt activeValid", activeValid, 1);
    check("R10", "unrelated corrupt wipe", zeroBusy, 0);
    check("R10", "unrelated corrupt rederive", rederiveReq, 0);

    // R10 retiring slot wiped early
    offer(4'd4);
    corruptSlot = 4'd9; corruptAlarm = 1'b1; step(); corruptAlarm = 1'b0;
    check("R10", "early wipe busy", zeroBusy, 1);
    check("R10", "early wipe mask", zeroMask, 16'h0200);
    waitWipe(bc);
    step();
    check("R10", "retire released", retireValid, 0);

    // R9 corrupt active
    corruptSlot = 4'd4; corruptAlarm = 1'b1; step(); corruptAlarm = 1'b0;
    check("R9", "rederiveReq", rederiveReq, 1);
    check("R9", "rederiveSlot", rederiveSlot, 4);
    check("R9", "activeValid", activeValid, 0);
    check("R9", "needKey", needKey, 1);
    step();
    check("R9", "rederive is a pulse", rederiveReq, 0);
    offer(4'd4);
    check("R9", "reinstalled", activeValid, 1);
    check("R9", "no grace on recovery", retireValid, 0);

    // R8 tamper
    tamperAlarm = 1'b1; step(); tamperAlarm = 1'b0;
    check("R8", "all slots wiped", zeroMask, 16'hFFFF);
    check("R8", "activeValid", activeValid, 0);
    check("R8", "needKey", needKey, 1);
    offer(4'd1);
    check("R8", "offer during wipe refused", activeValid, 0);
    waitWipe(bc);
    offer(4'd1);
    check("R8", "key after wipe", activeSlot, 1);
    check("R8", "key valid after wipe", activeValid, 1);
    check("R8", "no retire after tamper", retireValid, 0);

    // R3 counters restarted by install
    ticks(AGE_LIM - 1);
    check("R3", "age restarted: 599", rotateReq, 0);
    ticks(1);
    check("R3", "age restarted: 600", rotateReq, 1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule